// File: doc/BRIEF.md
# Buffered UART Receiver With Status Flags

This block turns an asynchronous serial line into 8-bit bytes and keeps them in a 16-entry first-word-fall-through queue until a host collects them. All bit timing comes from a one-cycle enable pulse, supplied from outside, that runs at sixteen times the baud rate. For example, 115200 baud from a 50 MHz clock needs a pulse every 27 clocks.

The serial input first passes through two flip-flops to synchronize it. A falling edge counts as a start bit only if the line is still low eight enable pulses later, which is the middle of the start bit. After that, each data bit is sampled every sixteen pulses, least significant bit first. The stop bit is then sampled in the same way. A frame with a low stop bit is thrown away. A good frame is written into the queue unless the queue is full, in which case the byte is lost and the stored bytes stay as they were.

The host always sees the oldest stored byte on the data output. It reads that byte first and then raises the pop pulse for one clock, so the next byte appears on the following clock. Three flags report the queue level: data present, half full and full.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty, and the data-present, half-full and full flags are all low.
- R2: While the queue holds data, the data output shows the oldest byte. A pop in a clock cycle removes that byte, and the next byte is on the output from the following cycle. A pop while the queue is empty has no effect.
- R3: Data present is high exactly when one or more bytes are stored.
- R4: Half full is high exactly when 8 or more of the 16 entries are occupied.
- R5: Full is high exactly when all 16 entries are occupied. A byte that completes while the queue is full is dropped, and the stored bytes and their order stay unchanged.
- R6: Receiver timing advances only in cycles where the 16x enable is high. While the enable is held low, no frame is started, sampled or stored, whatever the line does.
- R7: A falling edge starts a frame only if the line is still low on the 8th enable pulse after it was first seen low. Otherwise the receiver returns to idle without storing anything.
- R8: Data bits are sampled every 16 enable pulses after start validation, least significant bit first. A frame whose stop bit samples high stores the assembled byte.
- R9: A frame whose stop bit samples low is discarded, and the receiver waits for the line to go high before it accepts a new start edge.
- R10: The serial input passes through a two-stage synchronizer, so a line change is seen by the receiver two clocks after it appears at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at 16 times the baud rate |
| rxd | input | 1 | Serial input, idles high |
| pop | input | 1 | Removes the byte currently shown on rd_data |
| rd_data | output | 8 | Oldest stored byte |
| has_data | output | 1 | Queue not empty |
| half_full | output | 1 | 8 or more bytes stored |
| full | output | 1 | 16 bytes stored |

## Verification
The bench sends clean frames of varied bytes. These show whether the bit order is correct and whether sampling lands in the middle of each bit. It also sends a short low glitch, a frame with a low stop bit, and a long low level while the enable is stopped. These separate correct start validation, stop checking and enable gating from a receiver that stores whatever it sees. It then sends seventeen frames into the queue and drains it. This exposes errors at the half-full and full thresholds, overwriting on overflow, and lost or reordered bytes on pop. A behavioural model driven by the same stimulus is compared with every output on every clock, so a one-cycle timing slip is caught as well as a wrong value.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             has_data,
  output logic             half_full,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} rx_state_t;

  rx_state_t        state;
  logic             s1, s2, armed;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    nbit;
  logic [WIDTH-1:0] sh;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;
  logic             push, push_ok, do_pop;

  assign push      = tick && state == STOP && cnt == LAST && s2;
  assign push_ok   = push && !full;
  assign do_pop    = pop && has_data;
  assign rd_data   = mem[rptr];
  assign has_data  = count != '0;
  assign half_full = count >= (AW+1)'(DEPTH/2);
  assign full      = count == (AW+1)'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      state <= IDLE;
      armed <= 1'b0;
      cnt <= '0;
      nbit <= '0;
      sh <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (tick) begin
        case (state)
          IDLE:
            if (s2) armed <= 1'b1;
            else if (armed) begin
              state <= START;
              cnt <= '0;
              armed <= 1'b0;
            end
          START:
            if (cnt == MID) begin
              cnt <= '0;
              nbit <= '0;
              if (!s2) state <= DATA;
              else begin
                state <= IDLE;
                armed <= 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          DATA:
            if (cnt == LAST) begin
              cnt <= '0;
              sh <= {s2, sh[WIDTH-1:1]};
              nbit <= nbit + 1'b1;
              if (nbit == BW'(WIDTH-1)) state <= STOP;
            end else cnt <= cnt + 1'b1;
          default:
            if (cnt == LAST) begin
              cnt <= '0;
              state <= IDLE;
              armed <= s2;
            end else cnt <= cnt + 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (do_pop) rptr <= rptr + 1'b1;
      case ({push_ok, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full && $stable(wptr) && $stable(rptr));
  p_full_implies_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half_full && has_data);
  p_pop_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    has_data && pop |=> rptr == $past(rptr) + 1'b1);
  p_empty_pop_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !has_data && pop |=> $stable(rptr));
  p_hold_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state) && $stable(cnt) && $stable(sh));
  p_bad_stop_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && state == STOP && cnt == LAST && !s2 && !pop |=> $stable(count));
endmodule

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1, pop = 1'b0;
  logic [7:0] rd_data;
  logic has_data, half_full, full;
  logic tick_en = 1'b1;
  int div = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  uart_rx_queue uut (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .pop(pop),
    .rd_data(rd_data), .has_data(has_data), .half_full(half_full), .full(full));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (!tick_en) tick <= 1'b0;
    else begin
      tick <= (div == 3);
      div <= (div == 3) ? 0 : div + 1;
    end
  end

  // behavioural reference
  byte unsigned q[$];
  int m1 = 1, m2 = 1, ph = 0, mc = 0, mb = 0, marm = 0;
  int msh = 0;

  always @(posedge clk) begin
    int line;
    bit mpush, was_full;
    if (!rst_n) begin
      q.delete(); m1 = 1; m2 = 1; ph = 0; mc = 0; mb = 0; marm = 0; msh = 0;
    end else begin
      line = m2; m2 = m1; m1 = rxd;     // R10 two-clock delay
      mpush = 0;
      if (tick) begin
        if (ph == 0) begin
          if (line == 1) marm = 1;
          else if (marm == 1) begin ph = 1; mc = 0; marm = 0; end
        end else if (ph == 1) begin
          if (mc == 7) begin
            mc = 0; mb = 0;
            if (line == 0) ph = 2; else begin ph = 0; marm = 1; end
          end else mc++;
        end else if (ph == 2) begin
          if (mc == 15) begin
            mc = 0; msh = (msh >> 1) | (line << 7); mb++;
            if (mb == 8) ph = 3;
          end else mc++;
        end else begin
          if (mc == 15) begin
            mc = 0; ph = 0; marm = line; mpush = (line == 1);
          end else mc++;
        end
      end
      was_full = (q.size() == 16);
      if (pop && q.size() > 0) void'(q.pop_front());
      if (mpush && !was_full) q.push_back(byte'(msh));
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(has_data == (q.size() > 0), "R3 R10 has_data", has_data, q.size() > 0);
      chk(half_full == (q.size() >= 8), "R4 half_full", half_full, q.size() >= 8);
      chk(full == (q.size() == 16), "R5 full", full, q.size() == 16);
      if (q.size() > 0) chk(rd_data == q[0], "R2 R8 rd_data", rd_data, q[0]);
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic send_frame(input byte unsigned b, input bit stopv);
    rxd = 1'b0; wait_ticks(16);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_ticks(16); end
    rxd = stopv; wait_ticks(16);
    rxd = 1'b1; wait_ticks(4);
  endtask

  task automatic pop_one;
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    chk(!has_data && !half_full && !full, "R1 reset flags", {has_data, half_full, full}, 0);
    rst_n = 1'b1;
    wait_ticks(10);
    chk(!has_data, "R1 empty after reset", has_data, 0);

    send_frame(8'hA5, 1'b1);
    chk(has_data && rd_data == 8'hA5, "R8 byte A5 lsb first", rd_data, 8'hA5);
    pop_one();
    chk(!has_data, "R2 pop empties", has_data, 0);
    pop_one();
    chk(!has_data && !full, "R2 pop on empty ignored", has_data, 0);

    rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(20);
    chk(!has_data, "R7 short glitch rejected", has_data, 0);

    send_frame(8'h3C, 1'b0);
    wait_ticks(20);
    chk(!has_data, "R9 bad stop discarded", has_data, 0);
    send_frame(8'h81, 1'b1);
    chk(has_data && rd_data == 8'h81, "R9 recovers after bad stop", rd_data, 8'h81);
    pop_one();

    tick_en = 1'b0;
    rxd = 1'b0; repeat (300) @(negedge clk);
    rxd = 1'b1; repeat (10) @(negedge clk);
    tick_en = 1'b1;
    wait_ticks(20);
    chk(!has_data, "R6 no activity without enable", has_data, 0);

    for (int i = 0; i < 8; i++) send_frame(byte'(i * 17 + 3), 1'b1);
    chk(half_full && !full, "R4 half at 8", {half_full, full}, 2'b10);
    for (int i = 8; i < 16; i++) send_frame(byte'(i * 17 + 3), 1'b1);
    chk(full, "R5 full at 16", full, 1);
    send_frame(8'hEE, 1'b1);
    chk(full && rd_data == 8'h03, "R5 overflow drops byte", rd_data, 8'h03);
    for (int i = 0; i < 16; i++) begin
      chk(rd_data == byte'(i * 17 + 3), "R2 drain order", rd_data, byte'(i * 17 + 3));
      pop_one();
    end
    chk(!has_data && !half_full, "R3 empty after drain", has_data, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule